// File: doc/BRIEF.md
# Sequenced Hardware Monitor with Limit Interrupts

This block steps through a fixed list of ten measurement slots in a round-robin sequence. For each enabled slot it asks an external converter for a conversion and waits a dwell time that depends on the kind of slot. It then takes the result, stores it in that slot's value register and compares it against the slot's high and low limits. A result outside its limits sets a sticky status bit. Any status bit that is not masked drives an active-low interrupt output, but only while the global interrupt enable is set.

The converter is reached over two valid/ready channels. On the request channel, `cnv_req_valid` stays high with a stable `cnv_req_slot` and `cnv_req_remote` until the converter raises `cnv_req_ready`. The handshake completes on the clock edge where both are high. On the result channel the block raises `cnv_rsp_ready` only after the dwell time has passed. A result is taken only on an edge where `cnv_rsp_valid` and `cnv_rsp_ready` are both high, so the converter may hold its result for any length of time. At most one conversion is in flight. Software reaches all registers through a plain address/data port. A write takes effect on the clock edge where `reg_wr` is high. Read data appears on `reg_rdata` one cycle after `reg_rd`.

Slots: 0 and 1 are shared inputs, 2 is the first core voltage, 3 is the 2.5 V input or the second remote diode, 4 is the second core voltage, 5 is the 12 V rail, 6 is the 5 V rail, 7 is the internal supply, 8 is the internal temperature and 9 is the first remote diode. Register map: configuration 40h (bit 1 = interrupt enable), status A 41h (slots 0..7 in bits 0..7), status B 42h (slots 8, 9 in bits 0, 1), status A mirror 4Ch, status B mirror 4Dh, mask A 43h, mask B 44h, channel mode 47h, value 20h+slot, high limit 50h+slot, low limit 60h+slot.

Top module: `seqmon`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register holds its default. Configuration, mode, masks, status and values are 0. High limits are FFh and low limits are 00h, except slots 8 and 9, whose high limits are 7Fh and low limits are 80h. `int_n` is high, and the first request is for slot 2.
- R2: Slots are requested in ascending index order with wrap-around, and disabled slots are skipped. Slots 2, 5, 6, 7, 8 and 9 are always enabled. Slot 0 is enabled when mode bit 0 is 1, and slot 1 is enabled when mode bit 1 is 1. The mode register value at the edge where a result is taken decides the next slot.
- R3: Mode bit 2 sets the kind of slots 3 and 4. When it is 0, slots 3 and 4 are both voltage slots with `cnv_req_remote` = 0. When it is 1, slot 3 is a remote-temperature slot with `cnv_req_remote` = 1 and slot 4 is skipped. Slot 9 always has `cnv_req_remote` = 1. A slot's kind is fixed when the slot is picked.
- R4: After a request handshake, `cnv_rsp_ready` stays low for exactly SHORT_CYC cycles on non-remote slots and exactly LONG_CYC cycles on remote slots. It then stays high until the result handshake.
- R5: `cnv_req_valid` holds with a stable slot and kind until `cnv_req_ready`. `cnv_req_valid` and `cnv_rsp_ready` are never high together. A result is taken only when `cnv_rsp_valid` and `cnv_rsp_ready` are both high, and it is written to value register 20h+slot on that edge.
- R6: A result is out of limit when it is strictly greater than its high limit or strictly less than its low limit. The comparison is two's-complement for slot 8, slot 9 and remote slot 3, and unsigned for every other slot. An out-of-limit result sets the slot's status bit; any other result leaves status unchanged.
- R7: Status bits are sticky. A read of 41h or 4Ch returns status A, and a read of 42h or 4Dh returns status B in bits 1:0. The read clears only the bits it returned; an event on the same edge stays set. Writes to the status addresses have no effect.
- R8: A mask bit of 1 (mask A bit i for slot i, mask B bits 1:0 for slots 8 and 9) keeps its status bit off the interrupt.
- R9: `int_n` is low exactly when configuration bit 1 is 1 and at least one status bit is set with its mask bit clear.
- R10: The limits, masks, mode bits 2:0 and configuration bit 1 read back as written. Unimplemented bits and unmapped addresses read 0. Writes to value registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, one cycle after reg_rd |
| cnv_req_valid | output | 1 | Conversion request valid |
| cnv_req_ready | input | 1 | Converter accepts request |
| cnv_req_slot | output | 4 | Slot to convert |
| cnv_req_remote | output | 1 | Slot is a remote-diode slot |
| cnv_rsp_valid | input | 1 | Converter result valid |
| cnv_rsp_ready | output | 1 | Block accepts result |
| cnv_rsp_data | input | DATA_W | Conversion result |
| int_n | output | 1 | Active-low interrupt |

## Verification
The converter first answers at once and then under pseudo-random stalls on both channels. The first case pins down the exact dwell counts, and the second shows that slot order and result capture survive back-pressure. The sequence is run with mode values 0, 3, 4 and 7, which separate the always-enabled slots from the optional ones and the voltage pair from the second remote slot. Limit values sit exactly at, one beyond and across the sign boundary of the limits. These tell strict from inclusive comparison and signed from unsigned comparison. Status reads at the primary and mirror addresses, during live conversions, are used with mask and enable changes to tell read-clear from sticky behaviour and to check the gating of `int_n`.

// File: rtl/seqmon_pkg.sv
package seqmon_pkg;
  localparam int NSLOT  = 10;
  localparam int SLOT_W = 4;
  localparam int ADDR_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {ST_REQ, ST_DWELL, ST_RSP} seq_st_e;

  localparam logic [ADDR_W-1:0] A_CFG  = 8'h40;
  localparam logic [ADDR_W-1:0] A_STA  = 8'h41;
  localparam logic [ADDR_W-1:0] A_STB  = 8'h42;
  localparam logic [ADDR_W-1:0] A_MSKA = 8'h43;
  localparam logic [ADDR_W-1:0] A_MSKB = 8'h44;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h47;
  localparam logic [ADDR_W-1:0] A_MIRA = 8'h4C;
  localparam logic [ADDR_W-1:0] A_MIRB = 8'h4D;
  localparam logic [ADDR_W-1:0] A_VAL  = 8'h20;
  localparam logic [ADDR_W-1:0] A_HI   = 8'h50;
  localparam logic [ADDR_W-1:0] A_LO   = 8'h60;

  // slot enable as a function of the channel mode bits
  function automatic logic slot_on(input int s, input logic [MODE_W-1:0] m);
    case (s)
      0:       return m[0];
      1:       return m[1];
      4:       return !m[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic slot_remote(input int s, input logic [MODE_W-1:0] m);
    return (s == 9) || ((s == 3) && m[2]);
  endfunction

  function automatic logic slot_signed(input int s, input logic [MODE_W-1:0] m);
    return (s == 8) || slot_remote(s, m);
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] cur,
                                                  input logic [MODE_W-1:0] m);
    logic [SLOT_W-1:0] r;
    logic              hit;
    r   = cur;
    hit = 1'b0;
    for (int k = 1; k <= NSLOT; k++) begin
      int idx;
      idx = (int'(cur) + k) % NSLOT;
      if (!hit && slot_on(idx, m)) begin
        r   = SLOT_W'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/seqmon_seq.sv
module seqmon_seq
  import seqmon_pkg::*;
#(
  parameter int SHORT_CYC = 94375,
  parameter int LONG_CYC  = 4150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SLOT_W-1:0] req_slot,
  output logic              req_remote,
  output logic              rsp_ready,
  input  logic              rsp_valid,
  output logic              done,
  output logic [SLOT_W-1:0] done_slot,
  output logic              done_signed
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [SLOT_W-1:0] FIRST   = next_slot(SLOT_W'(NSLOT - 1), MODE_W'(0));
  localparam logic FIRST_REM = slot_remote(int'(FIRST), MODE_W'(0));
  localparam logic FIRST_SGN = slot_signed(int'(FIRST), MODE_W'(0));

  seq_st_e           st;
  logic [SLOT_W-1:0] cur;
  logic              cur_rem;
  logic              cur_sgn;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] nxt;

  always_comb nxt = next_slot(cur, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_REQ;
      cur     <= FIRST;
      cur_rem <= FIRST_REM;
      cur_sgn <= FIRST_SGN;
      cnt     <= '0;
    end else begin
      case (st)
        ST_REQ: begin
          if (req_ready) begin
            st  <= ST_DWELL;
            cnt <= cur_rem ? LONG_LD : SHORT_LD;
          end
        end
        ST_DWELL: begin
          if (cnt == '0) st <= ST_RSP;
          else           cnt <= cnt - 1'b1;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            st      <= ST_REQ;
            cur     <= nxt;
            cur_rem <= slot_remote(int'(nxt), mode);
            cur_sgn <= slot_signed(int'(nxt), mode);
          end
        end
        default: st <= ST_REQ;
      endcase
    end
  end

  assign req_valid   = (st == ST_REQ);
  assign req_slot    = cur;
  assign req_remote  = cur_rem;
  assign rsp_ready   = (st == ST_RSP);
  assign done        = (st == ST_RSP) && rsp_valid;
  assign done_slot   = cur;
  assign done_signed = cur_sgn;
endmodule

// File: rtl/seqmon_cmp.sv
module seqmon_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic          is_signed,
  output logic          oor
);
  logic above;
  logic below;

  always_comb begin
    if (is_signed) begin
      above = $signed(val) > $signed(hi);
      below = $signed(val) < $signed(lo);
    end else begin
      above = val > hi;
      below = val < lo;
    end
    oor = above || below;
  end
endmodule

// File: rtl/seqmon_regs.sv
module seqmon_regs
  import seqmon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic              done,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic [DW-1:0]     done_data,
  input  logic              oor,
  output logic [DW-1:0]     lim_hi,
  output logic [DW-1:0]     lim_lo,
  output logic              int_en,
  output logic [MODE_W-1:0] mode,
  output logic [NSLOT-1:0]  stat,
  output logic [NSLOT-1:0]  mask
);
  localparam int NB = NSLOT - DW;

  function automatic logic [DW-1:0] hi_rst(input int i);
    return slot_signed(i, MODE_W'(0)) ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  endfunction

  function automatic logic [DW-1:0] lo_rst(input int i);
    return slot_signed(i, MODE_W'(0)) ? {1'b1, {(DW-1){1'b0}}} : {DW{1'b0}};
  endfunction

  logic [DW-1:0]    val_q [NSLOT];
  logic [DW-1:0]    hi_q  [NSLOT];
  logic [DW-1:0]    lo_q  [NSLOT];
  logic [DW-1:0]    rmux;
  logic [NSLOT-1:0] clr;
  logic [NSLOT-1:0] evt;
  logic             rd_a;
  logic             rd_b;

  // limits of the slot whose result is being taken
  always_comb begin
    lim_hi = '0;
    lim_lo = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (done_slot == SLOT_W'(i)) begin
        lim_hi = hi_q[i];
        lim_lo = lo_q[i];
      end
    end
  end

  // per-slot value and limit registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        val_q[i] <= '0;
        hi_q[i]  <= hi_rst(i);
        lo_q[i]  <= lo_rst(i);
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (done && (done_slot == SLOT_W'(i))) val_q[i] <= done_data;
        if (reg_wr && (reg_addr == (A_HI + ADDR_W'(i)))) hi_q[i] <= reg_wdata;
        if (reg_wr && (reg_addr == (A_LO + ADDR_W'(i)))) lo_q[i] <= reg_wdata;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= 1'b0;
      mode   <= '0;
      mask   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG)  int_en         <= reg_wdata[1];
      if (reg_addr == A_MODE) mode           <= reg_wdata[MODE_W-1:0];
      if (reg_addr == A_MSKA) mask[DW-1:0]   <= reg_wdata;
      if (reg_addr == A_MSKB) mask[NSLOT-1:DW] <= reg_wdata[NB-1:0];
    end
  end

  // sticky status with snapshot clear on read
  assign rd_a = reg_rd && ((reg_addr == A_STA) || (reg_addr == A_MIRA));
  assign rd_b = reg_rd && ((reg_addr == A_STB) || (reg_addr == A_MIRB));

  always_comb begin
    clr = '0;
    if (rd_a) clr[DW-1:0]     = stat[DW-1:0];
    if (rd_b) clr[NSLOT-1:DW] = stat[NSLOT-1:DW];
    evt = (done && oor) ? (NSLOT'(1) << done_slot) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | evt;
  end

  // read path
  always_comb begin
    rmux = '0;
    if (reg_addr == A_CFG)  rmux[1] = int_en;
    if (reg_addr == A_MODE) rmux[MODE_W-1:0] = mode;
    if ((reg_addr == A_STA) || (reg_addr == A_MIRA)) rmux = stat[DW-1:0];
    if ((reg_addr == A_STB) || (reg_addr == A_MIRB)) rmux[NB-1:0] = stat[NSLOT-1:DW];
    if (reg_addr == A_MSKA) rmux = mask[DW-1:0];
    if (reg_addr == A_MSKB) rmux[NB-1:0] = mask[NSLOT-1:DW];
    for (int i = 0; i < NSLOT; i++) begin
      if (reg_addr == (A_VAL + ADDR_W'(i))) rmux = val_q[i];
      if (reg_addr == (A_HI  + ADDR_W'(i))) rmux = hi_q[i];
      if (reg_addr == (A_LO  + ADDR_W'(i))) rmux = lo_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rmux;
  end
endmodule

// File: rtl/seqmon.sv
module seqmon
  import seqmon_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHORT_CYC = 94375,
  parameter int LONG_CYC  = 4150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cnv_req_valid,
  input  logic              cnv_req_ready,
  output logic [SLOT_W-1:0] cnv_req_slot,
  output logic              cnv_req_remote,
  input  logic              cnv_rsp_valid,
  output logic              cnv_rsp_ready,
  input  logic [DATA_W-1:0] cnv_rsp_data,
  output logic              int_n
);
  logic              done_w;
  logic [SLOT_W-1:0] done_slot_w;
  logic              done_sgn_w;
  logic              oor_w;
  logic [DATA_W-1:0] hi_w;
  logic [DATA_W-1:0] lo_w;
  logic              int_en_w;
  logic [MODE_W-1:0] mode_w;
  logic [NSLOT-1:0]  stat_w;
  logic [NSLOT-1:0]  mask_w;

  seqmon_seq #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_w),
    .req_valid   (cnv_req_valid),
    .req_ready   (cnv_req_ready),
    .req_slot    (cnv_req_slot),
    .req_remote  (cnv_req_remote),
    .rsp_ready   (cnv_rsp_ready),
    .rsp_valid   (cnv_rsp_valid),
    .done        (done_w),
    .done_slot   (done_slot_w),
    .done_signed (done_sgn_w)
  );

  seqmon_cmp #(.DW(DATA_W)) u_cmp (
    .val       (cnv_rsp_data),
    .hi        (hi_w),
    .lo        (lo_w),
    .is_signed (done_sgn_w),
    .oor       (oor_w)
  );

  seqmon_regs #(.DW(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .done      (done_w),
    .done_slot (done_slot_w),
    .done_data (cnv_rsp_data),
    .oor       (oor_w),
    .lim_hi    (hi_w),
    .lim_lo    (lo_w),
    .int_en    (int_en_w),
    .mode      (mode_w),
    .stat      (stat_w),
    .mask      (mask_w)
  );

  assign int_n = !(int_en_w && ((stat_w & ~mask_w) != '0));
endmodule

// File: rtl/seqmon_chk.sv
module seqmon_chk
  import seqmon_pkg::*;
#(
  parameter int SHORT_CYC = 94375,
  parameter int LONG_CYC  = 4150000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SLOT_W-1:0] req_slot,
  input logic              req_remote,
  input logic              rsp_ready,
  input logic              reg_rd,
  input logic              done,
  input logic              int_en,
  input logic              int_n,
  input logic [NSLOT-1:0]  stat,
  input logic [NSLOT-1:0]  mask
);
  logic [31:0] dw_cnt;
  logic        rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw_cnt <= '0;
      rem_q  <= 1'b0;
    end else if (req_valid && req_ready) begin
      dw_cnt <= '0;
      rem_q  <= req_remote;
    end else if (!req_valid && !rsp_ready) begin
      dw_cnt <= dw_cnt + 1'b1;
    end
  end

  a_r4_dwell_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> (dw_cnt == (rem_q ? 32'(LONG_CYC) : 32'(SHORT_CYC))));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_slot) && $stable(req_remote)));

  a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  a_r6_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ((stat & ~$past(stat)) == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> ((stat & $past(stat)) == $past(stat)));

  a_r9_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> int_n);

  a_r8_unmasked_src: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> ((stat & ~mask) != '0));
endmodule

bind seqmon seqmon_chk #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (cnv_req_valid),
  .req_ready  (cnv_req_ready),
  .req_slot   (cnv_req_slot),
  .req_remote (cnv_req_remote),
  .rsp_ready  (cnv_rsp_ready),
  .reg_rd     (reg_rd),
  .done       (done_w),
  .int_en     (int_en_w),
  .int_n      (int_n),
  .stat       (stat_w),
  .mask       (mask_w)
);

// File: tb/seqmon_tb_top.sv
module seqmon_tb_top;
  localparam int SHORT = 4;
  localparam int LONG  = 12;
  localparam int NS    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       cnv_req_valid;
  logic       cnv_req_ready = 1'b1;
  logic [3:0] cnv_req_slot;
  logic       cnv_req_remote;
  logic       cnv_rsp_valid = 1'b1;
  logic       cnv_rsp_ready;
  logic [7:0] cnv_rsp_data = 8'h00;
  logic       int_n;

  int vecs = 0;
  int miss = 0;

  // reference model state
  int         mstate;
  int         mcnt;
  int         mslot;
  bit         mremote;
  bit         msigned;
  logic [7:0] mval [NS];
  logic [7:0] mhi  [NS];
  logic [7:0] mlo  [NS];
  logic [9:0] mstat;
  logic [9:0] mmask;
  bit         mie;
  logic [2:0] mmode;
  bit         rd_pend;
  logic [7:0] rd_exp;
  string      rd_tag;
  string      rtag = "R1";
  logic [7:0] conv_tbl [NS];
  bit         bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  seqmon #(.DATA_W(8), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cnv_req_valid(cnv_req_valid), .cnv_req_ready(cnv_req_ready),
    .cnv_req_slot(cnv_req_slot), .cnv_req_remote(cnv_req_remote),
    .cnv_rsp_valid(cnv_rsp_valid), .cnv_rsp_ready(cnv_rsp_ready),
    .cnv_rsp_data(cnv_rsp_data), .int_n(int_n)
  );

  always #4 clk = ~clk;

  function automatic bit b_on(int s, logic [2:0] m);
    if (s == 0) return m[0];
    if (s == 1) return m[1];
    if (s == 4) return !m[2];
    return 1'b1;
  endfunction

  function automatic bit b_remote(int s, logic [2:0] m);
    return (s == 9) || (s == 3 && m[2]);
  endfunction

  function automatic int b_next(int s, logic [2:0] m);
    for (int k = 1; k <= NS; k++) begin
      if (b_on((s + k) % NS, m)) return (s + k) % NS;
    end
    return s;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (a == 8'h40) return {6'd0, mie, 1'b0};
    if (a == 8'h41 || a == 8'h4C) return mstat[7:0];
    if (a == 8'h42 || a == 8'h4D) return {6'd0, mstat[9:8]};
    if (a == 8'h43) return mmask[7:0];
    if (a == 8'h44) return {6'd0, mmask[9:8]};
    if (a == 8'h47) return {5'd0, mmode};
    for (int i = 0; i < NS; i++) begin
      if (a == 8'h20 + i) return mval[i];
      if (a == 8'h50 + i) return mhi[i];
      if (a == 8'h60 + i) return mlo[i];
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    mstate = 0; mcnt = 0; mslot = 2; mremote = 0; msigned = 0;
    for (int i = 0; i < NS; i++) begin
      mval[i] = 8'h00;
      mhi[i]  = (i >= 8) ? 8'h7F : 8'hFF;
      mlo[i]  = (i >= 8) ? 8'h80 : 8'h00;
    end
    mstat = '0; mmask = '0; mie = 0; mmode = '0; rd_pend = 0;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter emulation
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cnv_req_ready = bp_on ? lfsr[0] : 1'b1;
    cnv_rsp_valid = bp_on ? lfsr[5] : 1'b1;
    cnv_rsp_data  = conv_tbl[mslot];
  end

  // compare on every clock, then advance the model across the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit         oor;
      bit         exp_int;
      logic [9:0] clr;
      logic [9:0] evt;
      logic [2:0] mode_old;
      chk(cnv_req_valid == (mstate == 0), "R5 req_valid", cnv_req_valid, mstate == 0);
      if (mstate == 0) begin
        chk(cnv_req_slot == mslot, "R2 slot order", cnv_req_slot, mslot);
        chk(cnv_req_remote == mremote, "R3 slot kind", cnv_req_remote, mremote);
      end
      chk(cnv_rsp_ready == (mstate == 2), "R4 dwell", cnv_rsp_ready, mstate == 2);
      exp_int = !(mie && ((mstat & ~mmask) != 0));
      chk(int_n == exp_int, mie ? "R8 int_n mask" : "R9 int_n gate", int_n, exp_int);
      if (rd_pend) chk(reg_rdata == rd_exp, rd_tag, reg_rdata, rd_exp);
      rd_pend  = 0;
      mode_old = mmode;
      clr = '0;
      evt = '0;
      if (reg_rd) begin
        rd_exp  = m_read(reg_addr);
        rd_pend = 1;
        rd_tag  = (reg_addr inside {8'h41, 8'h42, 8'h4C, 8'h4D}) ? "R7 status read" :
                  (reg_addr inside {[8'h20:8'h29]}) ? "R5 value reg" : rtag;
        if (reg_addr == 8'h41 || reg_addr == 8'h4C) clr[7:0] = mstat[7:0];
        if (reg_addr == 8'h42 || reg_addr == 8'h4D) clr[9:8] = mstat[9:8];
      end
      case (mstate)
        0: if (cnv_req_ready) begin
             mstate = 1;
             mcnt = mremote ? LONG - 1 : SHORT - 1;
           end
        1: if (mcnt == 0) mstate = 2; else mcnt--;
        default: if (cnv_rsp_valid) begin
             if (msigned)
               oor = ($signed(cnv_rsp_data) > $signed(mhi[mslot])) ||
                     ($signed(cnv_rsp_data) < $signed(mlo[mslot]));
             else
               oor = (cnv_rsp_data > mhi[mslot]) || (cnv_rsp_data < mlo[mslot]);
             if (oor) evt[mslot] = 1'b1;
             mval[mslot] = cnv_rsp_data;
             mslot   = b_next(mslot, mode_old);
             mremote = b_remote(mslot, mode_old);
             msigned = mremote || (mslot == 8);
             mstate  = 0;
           end
      endcase
      mstat = (mstat & ~clr) | evt;
      if (reg_wr) begin
        if (reg_addr == 8'h40) mie = reg_wdata[1];
        if (reg_addr == 8'h43) mmask[7:0] = reg_wdata;
        if (reg_addr == 8'h44) mmask[9:8] = reg_wdata[1:0];
        if (reg_addr == 8'h47) mmode = reg_wdata[2:0];
        for (int i = 0; i < NS; i++) begin
          if (reg_addr == 8'h50 + i) mhi[i] = reg_wdata;
          if (reg_addr == 8'h60 + i) mlo[i] = reg_wdata;
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #2;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic read_defaults();
    rtag = "R1";
    foreach (conv_tbl[i]) rd(8'h50 + 8'(i));
    foreach (conv_tbl[i]) rd(8'h60 + 8'(i));
    rd(8'h40); rd(8'h41); rd(8'h42); rd(8'h43); rd(8'h44); rd(8'h47);
    rd(8'h4C); rd(8'h4D);
    rtag = "R10";
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    vecs++; miss++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    foreach (conv_tbl[i]) conv_tbl[i] = 8'h40;
    conv_tbl[8] = 8'h19;
    conv_tbl[9] = 8'h19;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    read_defaults();
    wait_cyc(80);
    // R6 unsigned above-limit on slot 2, R9 enable, R8 mask
    wr(8'h52, 8'h80);
    conv_tbl[2] = 8'h90;
    wait_cyc(80);
    rd(8'h41);
    wr(8'h40, 8'h02);
    rd(8'h40);
    wait_cyc(80);
    wr(8'h43, 8'h04);
    rd(8'h43);
    wait_cyc(40);
    wr(8'h43, 8'h00);
    rd(8'h4C);
    rd(8'h41);
    // R7 status write has no effect
    wr(8'h41, 8'hFF);
    wr(8'h42, 8'hFF);
    rd(8'h41);
    rd(8'h42);
    conv_tbl[2] = 8'h40;
    // R6 strict bounds and signed temperature limits
    wr(8'h58, 8'h10); wr(8'h68, 8'hF0);
    wr(8'h59, 8'h10); wr(8'h69, 8'hF0);
    conv_tbl[8] = 8'h05;
    conv_tbl[9] = 8'hF8;
    wr(8'h55, 8'hF0); conv_tbl[5] = 8'hF8;
    wr(8'h66, 8'h20); conv_tbl[6] = 8'h20;
    wr(8'h57, 8'h30); conv_tbl[7] = 8'h30;
    wait_cyc(160);
    rd(8'h41); rd(8'h42); rd(8'h4D);
    wait_cyc(100);
    rd(8'h41); rd(8'h42);
    conv_tbl[8] = 8'hE0;
    wait_cyc(120);
    rd(8'h4D); rd(8'h28); rd(8'h29);
    wr(8'h44, 8'h01);
    wait_cyc(60);
    wr(8'h44, 8'h00);
    // R2 optional slots enabled
    wr(8'h50, 8'h50); conv_tbl[0] = 8'h55;
    conv_tbl[1] = 8'h33;
    wr(8'h47, 8'h03);
    rd(8'h47);
    wait_cyc(160);
    rd(8'h20); rd(8'h21); rd(8'h41);
    // R3 second remote slot
    wr(8'h53, 8'h10); wr(8'h63, 8'hF0);
    conv_tbl[3] = 8'hF8;
    wr(8'h47, 8'h04);
    wait_cyc(200);
    rd(8'h23); rd(8'h41); rd(8'h42);
    conv_tbl[3] = 8'h20;
    wait_cyc(120);
    rd(8'h41);
    // R5 back-pressure on both channels, all modes on
    wr(8'h47, 8'h07);
    bp_on = 1'b1;
    wait_cyc(500);
    rd(8'h41); rd(8'h4C); rd(8'h42);
    wr(8'h20, 8'hAA);
    rd(8'h20);
    rd(8'h7E);
    wr(8'h47, 8'h00);
    wait_cyc(300);
    bp_on = 1'b0;
    rd(8'h41); rd(8'h42);
    wait_cyc(60);
    // R1 reset in mid-run
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    read_defaults();
    wait_cyc(100);
    finish_run();
  end
endmodule